// File: doc/BRIEF.md
# Serial Real-Time-Clock Command Slave

This block is the device end of a bit-serial real-time-clock link. The host frames each transaction by holding a chip enable high and toggling a serial clock. Each rising edge of the serial clock is one phase. The first eight phases deliver a command byte, most significant bit first. The next eight phases either carry a data byte into the block or carry one back out, depending on the command.

Behind the link the block holds the following state:
- a 32-byte scratch RAM;
- a fixed status byte;
- a writable control byte;
- a BCD time-of-day clock, advanced by a one-second tick input.

Day, month and year read as constants set by parameters. The serial clock and data inputs are sampled in the system clock domain. A serial clock edge is seen one system clock after the rising level appears. Every bit driven on a read is also collected into a byte that the host can see.

Top module: `rtc_serial_slave`

## Requirements
- R1: While chip enable is high, each rising edge of the serial clock advances the phase by one. Phases 0 to 7 shift the command byte in, first bit as bit 7.
- R2: A command is a write only if it lies in 0x80..0x9F or equals 0xB1. Every other value is a read. A read of a command with no mapped source returns 0x00: 0x32..0x7F, 0xA0..0xB0 and 0xB2..0xFF all read as 0x00. Data bits sent with such a read change no stored state.
- R3: On a write command in 0x80..0x9F, phases 8..15 shift in a data byte, first bit as bit 7. When phase 15 completes, the byte is stored at RAM address (command − 0x80).
- R4: Write command 0xB1 stores its data byte into the control register. Read command 0x31 returns that register, which is 0x00 after reset.
- R5: Read commands 0x00..0x1F return the RAM byte at the address equal to the command. During data phase p, the output carries bit 7−(p−8), so the byte goes out MSB first. RAM is 0x00 after reset.
- R6: Read command 0x30 returns the status byte 0x98.
- R7: Read commands 0x20..0x2F return BCD time fields: 0x20 seconds, 0x21 minutes, 0x22 hours, 0x24 day (01), 0x25 month (01) and 0x26 year since 2000 (00). Every other command in that range reads 0x00. After reset the time is 00:00:00.
- R8: On a read, each driven bit is also shifted into the 8-bit return value from the LSB side. After the 16th phase, the return value equals the byte that was read. The return value is 0x00 after reset.
- R9: Dropping chip enable returns the phase to 0 and abandons a partial transaction. A write cut short before phase 15 completes stores nothing.
- R10: After phase 15 the block ignores further serial clock edges until the next framing. It stores nothing more and drives nothing more.
- R11: Each cycle with the tick input high adds one second. Seconds wrap 59→00 and carry into minutes, minutes wrap 59→00 and carry into hours, and hours wrap 23→00.
- R12: The data output enable is high only during data phases 8..15 of a read command while chip enable is high. At all other times it is low, and the data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipEn | input | 1 | Transaction frame, high while active |
| serClk | input | 1 | Serial clock level; a rising edge is one phase |
| serDataIn | input | 1 | Serial data from the host |
| secTick | input | 1 | One-second tick, one increment per high cycle |
| serDataOut | output | 1 | Serial data to the host during read phases |
| serDataOe | output | 1 | Enable for serDataOut |
| retValue | output | 8 | Bits collected from read phases |

## Verification
The situation hardest to reach from the ports is the midnight wrap of the hour counter, which needs a full day of ticks. The stimulus gets there by holding the tick input high for long runs, so that one second passes per system clock. It checks the time after the first minute carry, at 23:59:59 and after the final wrap. A second hard situation is a write abandoned inside its data phases. Another is serial clocks that continue past phase 15. Directed transactions produce both, and a read-back then shows whether any stray store took place. Random transactions mix writes and reads over the full command space, including command bytes that only look like writes.

// File: rtl/rtc_serial_pkg.sv
package rtc_serial_pkg;
  localparam int BYTE_W    = 8;
  localparam int SEL_W     = $clog2(BYTE_W);
  localparam int LAST_PH   = 2 * BYTE_W - 1;
  localparam int PHASE_W   = $clog2(LAST_PH + 2);

  typedef struct packed {
    logic             wrShift;    // data phase edge of a write
    logic             rdShift;    // data phase edge of a read
    logic             rdDrive;    // read data phase in progress
    logic             storeRam;   // final edge of a RAM write
    logic             storeCtrl;  // final edge of a control write
    logic [SEL_W-1:0] bitSel;     // bit of the selected byte to drive
  } rtcStrobe_t;

  function automatic logic cmdIsWrite(input logic [BYTE_W-1:0] c);
    return (c >= 8'h80 && c <= 8'h9F) || (c == 8'hB1);
  endfunction

  function automatic logic [7:0] bcdNext(input logic [7:0] v, input logic [7:0] last);
    logic [7:0] n;
    if (v == last)          n = 8'h00;
    else if (v[3:0] == 4'd9) n = {v[7:4] + 4'd1, 4'd0};
    else                    n = v + 8'd1;
    return n;
  endfunction
endpackage

// File: rtl/rtc_serial_ctrl.sv
module rtc_serial_ctrl
  import rtc_serial_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               chipEn,
  input  logic               serClk,
  input  logic               serDataIn,
  output logic               sclkEdge,
  output logic [PHASE_W-1:0] phase,
  output logic [BYTE_W-1:0]  cmdByte,
  output rtcStrobe_t         strobe
);
  localparam logic [PHASE_W-1:0] CMD_PHASES = PHASE_W'(BYTE_W);
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(LAST_PH);
  localparam logic [SEL_W-1:0]   TOP_BIT    = SEL_W'(BYTE_W - 1);

  logic serClkQ;
  logic inData;
  logic isWrite;
  logic [PHASE_W-1:0] dataIdx;

  always_ff @(posedge clk) begin
    if (!rstN) serClkQ <= 1'b0;
    else       serClkQ <= serClk;
  end

  assign sclkEdge = serClk & ~serClkQ;

  always_ff @(posedge clk) begin
    if (!rstN || !chipEn)
      phase <= '0;
    else if (sclkEdge && phase <= LAST_PHASE)
      phase <= phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      cmdByte <= '0;
    else if (chipEn && sclkEdge && phase < CMD_PHASES)
      cmdByte <= {cmdByte[BYTE_W-2:0], serDataIn};
  end

  always_comb begin
    inData  = chipEn && (phase >= CMD_PHASES) && (phase <= LAST_PHASE);
    isWrite = cmdIsWrite(cmdByte);
    dataIdx = phase - CMD_PHASES;
    strobe.wrShift   = inData && sclkEdge && isWrite;
    strobe.rdShift   = inData && sclkEdge && !isWrite;
    strobe.rdDrive   = inData && !isWrite;
    strobe.storeRam  = strobe.wrShift && (phase == LAST_PHASE) && (cmdByte[7:5] == 3'b100);
    strobe.storeCtrl = strobe.wrShift && (phase == LAST_PHASE) && (cmdByte == 8'hB1);
    strobe.bitSel    = TOP_BIT - dataIdx[SEL_W-1:0];
  end
endmodule

// File: rtl/rtc_bcd_clock.sv
module rtc_bcd_clock
  import rtc_serial_pkg::*;
#(
  parameter logic [7:0] DAY_INIT  = 8'h01,
  parameter logic [7:0] MON_INIT  = 8'h01,
  parameter logic [7:0] YEAR_INIT = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  output logic [7:0] timeSec,
  output logic [7:0] timeMin,
  output logic [7:0] timeHour,
  output logic [7:0] timeDay,
  output logic [7:0] timeMon,
  output logic [7:0] timeYear
);
  localparam logic [7:0] SEC_LAST  = 8'h59;
  localparam logic [7:0] MIN_LAST  = 8'h59;
  localparam logic [7:0] HOUR_LAST = 8'h23;

  logic wrapSec;
  logic wrapMin;

  assign wrapSec = secTick && (timeSec == SEC_LAST);
  assign wrapMin = wrapSec && (timeMin == MIN_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeSec  <= 8'h00;
      timeMin  <= 8'h00;
      timeHour <= 8'h00;
    end else begin
      if (secTick) timeSec  <= bcdNext(timeSec, SEC_LAST);
      if (wrapSec) timeMin  <= bcdNext(timeMin, MIN_LAST);
      if (wrapMin) timeHour <= bcdNext(timeHour, HOUR_LAST);
    end
  end

  assign timeDay  = DAY_INIT;
  assign timeMon  = MON_INIT;
  assign timeYear = YEAR_INIT;
endmodule

// File: rtl/rtc_serial_datapath.sv
module rtc_serial_datapath
  import rtc_serial_pkg::*;
#(
  parameter int          RAM_DEPTH   = 32,
  parameter logic [7:0]  STATUS_INIT = 8'h98
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobe_t        strobe,
  input  logic [BYTE_W-1:0] cmdByte,
  input  logic              serDataIn,
  input  logic [7:0]        timeSec,
  input  logic [7:0]        timeMin,
  input  logic [7:0]        timeHour,
  input  logic [7:0]        timeDay,
  input  logic [7:0]        timeMon,
  input  logic [7:0]        timeYear,
  output logic              serDataOut,
  output logic              serDataOe,
  output logic [BYTE_W-1:0] retValue
);
  localparam int ADDR_W = $clog2(RAM_DEPTH);

  logic [BYTE_W-1:0] ram [RAM_DEPTH];
  logic [BYTE_W-1:0] ctrlReg;
  logic [BYTE_W-1:0] wrValue;
  logic [BYTE_W-1:0] wrWord;
  logic [BYTE_W-1:0] selByte;
  logic [BYTE_W-1:0] timeByte;
  logic              drvBit;

  assign wrWord = {wrValue[BYTE_W-2:0], serDataIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrValue <= '0;
      ctrlReg <= '0;
      for (int i = 0; i < RAM_DEPTH; i++) ram[i] <= '0;
    end else begin
      if (strobe.wrShift)   wrValue <= wrWord;
      if (strobe.storeCtrl) ctrlReg <= wrWord;
      if (strobe.storeRam)  ram[cmdByte[ADDR_W-1:0]] <= wrWord;
    end
  end

  always_comb begin
    case (cmdByte[3:0])
      4'h0:    timeByte = timeSec;
      4'h1:    timeByte = timeMin;
      4'h2:    timeByte = timeHour;
      4'h4:    timeByte = timeDay;
      4'h5:    timeByte = timeMon;
      4'h6:    timeByte = timeYear;
      default: timeByte = 8'h00;
    endcase
    if (cmdByte[BYTE_W-1:ADDR_W] == '0)
      selByte = ram[cmdByte[ADDR_W-1:0]];
    else if (cmdByte[7:4] == 4'h2)
      selByte = timeByte;
    else if (cmdByte == 8'h30)
      selByte = STATUS_INIT;
    else if (cmdByte == 8'h31)
      selByte = ctrlReg;
    else
      selByte = 8'h00;
  end

  assign drvBit     = selByte[strobe.bitSel];
  assign serDataOe  = strobe.rdDrive;
  assign serDataOut = strobe.rdDrive & drvBit;

  always_ff @(posedge clk) begin
    if (!rstN)              retValue <= '0;
    else if (strobe.rdShift) retValue <= {retValue[BYTE_W-2:0], drvBit};
  end
endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
  import rtc_serial_pkg::*;
#(
  parameter int         RAM_DEPTH   = 32,
  parameter logic [7:0] STATUS_INIT = 8'h98,
  parameter logic [7:0] DAY_INIT    = 8'h01,
  parameter logic [7:0] MON_INIT    = 8'h01,
  parameter logic [7:0] YEAR_INIT   = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chipEn,
  input  logic       serClk,
  input  logic       serDataIn,
  input  logic       secTick,
  output logic       serDataOut,
  output logic       serDataOe,
  output logic [7:0] retValue
);
  rtcStrobe_t         strobe;
  logic               sclkEdge;
  logic [PHASE_W-1:0] phase;
  logic [BYTE_W-1:0]  cmdByte;
  logic [7:0] timeSec, timeMin, timeHour, timeDay, timeMon, timeYear;

  rtc_serial_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .serClk(serClk),
    .serDataIn(serDataIn), .sclkEdge(sclkEdge), .phase(phase),
    .cmdByte(cmdByte), .strobe(strobe)
  );

  rtc_bcd_clock #(
    .DAY_INIT(DAY_INIT), .MON_INIT(MON_INIT), .YEAR_INIT(YEAR_INIT)
  ) uClock (
    .clk(clk), .rstN(rstN), .secTick(secTick),
    .timeSec(timeSec), .timeMin(timeMin), .timeHour(timeHour),
    .timeDay(timeDay), .timeMon(timeMon), .timeYear(timeYear)
  );

  rtc_serial_datapath #(
    .RAM_DEPTH(RAM_DEPTH), .STATUS_INIT(STATUS_INIT)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdByte(cmdByte),
    .serDataIn(serDataIn),
    .timeSec(timeSec), .timeMin(timeMin), .timeHour(timeHour),
    .timeDay(timeDay), .timeMon(timeMon), .timeYear(timeYear),
    .serDataOut(serDataOut), .serDataOe(serDataOe), .retValue(retValue)
  );
endmodule

// File: rtl/rtc_serial_slave_chk.sv
module rtc_serial_slave_chk
  import rtc_serial_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               chipEn,
  input logic               sclkEdge,
  input logic               secTick,
  input logic               serDataOe,
  input logic               serDataOut,
  input logic               storeRam,
  input logic [PHASE_W-1:0] phase,
  input logic [BYTE_W-1:0]  cmdByte,
  input logic [7:0]         timeSec,
  input logic [7:0]         timeMin,
  input logic [7:0]         timeHour
);
  assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (chipEn && sclkEdge && phase <= PHASE_W'(LAST_PH)) |=> (phase == $past(phase) + 1'b1));

  assert_store_last_phase_R3: assert property (@(posedge clk) disable iff (!rstN)
    storeRam |-> (phase == PHASE_W'(LAST_PH) && chipEn));

  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    !chipEn |=> (phase == '0));

  assert_phase_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PHASE_W'(LAST_PH + 1)) |=> (phase == PHASE_W'(LAST_PH + 1) || phase == '0));

  assert_sec_wrap_R11: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && timeSec == 8'h59) |=> (timeSec == 8'h00));

  assert_hour_wrap_R11: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && timeSec == 8'h59 && timeMin == 8'h59 && timeHour == 8'h23) |=> (timeHour == 8'h00));

  assert_sec_bcd_R11: assert property (@(posedge clk) disable iff (!rstN)
    (timeSec[3:0] <= 4'd9 && timeSec[7:4] <= 4'd5));

  assert_oe_window_R12: assert property (@(posedge clk) disable iff (!rstN)
    serDataOe |-> (chipEn && phase >= PHASE_W'(BYTE_W) && phase <= PHASE_W'(LAST_PH) && !cmdIsWrite(cmdByte)));

  assert_out_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !serDataOe |-> !serDataOut);
endmodule

bind rtc_serial_slave rtc_serial_slave_chk uChk (
  .clk(clk), .rstN(rstN), .chipEn(chipEn), .sclkEdge(sclkEdge),
  .secTick(secTick), .serDataOe(serDataOe), .serDataOut(serDataOut),
  .storeRam(strobe.storeRam), .phase(phase), .cmdByte(cmdByte),
  .timeSec(timeSec), .timeMin(timeMin), .timeHour(timeHour)
);

// File: tb/rtc_serial_slave_test.sv
module rtc_serial_slave_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipEn = 1'b0;
  logic serClk = 1'b0;
  logic serDataIn = 1'b0;
  logic secTick = 1'b0;
  logic serDataOut;
  logic serDataOe;
  logic [7:0] retValue;

  int total = 0;
  int bad = 0;
  int ticks = 0;
  logic [7:0] mRam [32];
  logic [7:0] mCtrl = 8'h00;

  always #5 clk = ~clk;

  rtc_serial_slave uut (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .serClk(serClk),
    .serDataIn(serDataIn), .secTick(secTick), .serDataOut(serDataOut),
    .serDataOe(serDataOe), .retValue(retValue)
  );

  function automatic bit isWr(input logic [7:0] c);
    return (c >= 8'h80 && c <= 8'h9F) || c == 8'hB1;
  endfunction

  function automatic logic [7:0] toBcd(input int n);
    return 8'((n / 10) * 16 + (n % 10));
  endfunction

  function automatic logic [7:0] expByte(input logic [7:0] c);
    logic [7:0] e;
    e = 8'h00;
    if (c < 8'h20) e = mRam[c[4:0]];
    else if (c == 8'h20) e = toBcd(ticks % 60);
    else if (c == 8'h21) e = toBcd((ticks / 60) % 60);
    else if (c == 8'h22) e = toBcd((ticks / 3600) % 24);
    else if (c == 8'h24) e = 8'h01;
    else if (c == 8'h25) e = 8'h01;
    else if (c == 8'h26) e = 8'h00;
    else if (c == 8'h30) e = 8'h98;
    else if (c == 8'h31) e = mCtrl;
    return e;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] wdata, input int nBits,
                      output logic [7:0] rd, output int oeErr);
    bit rdCmd;
    rdCmd = !isWr(cmd);
    rd = 8'h00;
    oeErr = 0;
    chipEn = 1'b1;
    for (int i = 0; i < nBits; i++) begin
      serClk = 1'b0;
      if (i < 8)       serDataIn = cmd[7 - i];
      else if (i < 16) serDataIn = wdata[15 - i];
      else             serDataIn = 1'($urandom);
      repeat (2) @(negedge clk);
      if (i >= 8 && i < 16) begin
        rd = {rd[6:0], serDataOut};
        if (serDataOe !== rdCmd) oeErr++;
      end else if (serDataOe !== 1'b0) oeErr++;
      serClk = 1'b1;
      repeat (2) @(negedge clk);
    end
    serClk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic endXfer();
    chipEn = 1'b0;
    repeat (2) @(negedge clk);
    check("R12 oe idle", serDataOe, 1'b0);
  endtask

  task automatic doWrite(input logic [7:0] cmd, input logic [7:0] val, input string req);
    logic [7:0] rd;
    int oeErr;
    xfer(cmd, val, 16, rd, oeErr);
    check({req, " oe low on write"}, oeErr, 0);
    endXfer();
    if (cmd >= 8'h80 && cmd <= 8'h9F) mRam[cmd[4:0]] = val;
    if (cmd == 8'hB1) mCtrl = val;
  endtask

  task automatic doRead(input logic [7:0] cmd, input string req, input int nBits = 16);
    logic [7:0] rd;
    logic [7:0] e;
    int oeErr;
    e = expByte(cmd);
    xfer(cmd, 8'($urandom), nBits, rd, oeErr);
    check({req, " read data"}, rd, e);
    check({req, " R8 retValue"}, retValue, e);
    check({req, " R12 oe window"}, oeErr, 0);
    endXfer();
  endtask

  task automatic tickRun(input int n);
    secTick = 1'b1;
    repeat (n) @(negedge clk);
    secTick = 1'b0;
    ticks += n;
    @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected<%0d", cyc, 190000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int oeErr;
    void'($urandom(32'h1234abcd));
    for (int i = 0; i < 32; i++) mRam[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    check("R12 reset oe", serDataOe, 1'b0);
    check("R8 reset retValue", retValue, 8'h00);
    doRead(8'h30, "R6 status");
    doRead(8'h20, "R7 seconds at reset");
    doRead(8'h31, "R4 control at reset");
    doRead(8'h1F, "R5 ram at reset");

    // RAM writes and reads, boundaries
    doWrite(8'h80, 8'hA5, "R3");
    doWrite(8'h9F, 8'h5A, "R3");
    doWrite(8'h85, 8'h3C, "R3");
    doRead(8'h00, "R5 addr0");
    doRead(8'h1F, "R5 addr31");
    doRead(8'h05, "R1 R5 addr5");

    // control write
    doWrite(8'hB1, 8'hC3, "R4");
    doRead(8'h31, "R4 control");

    // non-write commands near the write range
    doRead(8'hA1, "R2 0xA1 reads zero");
    doRead(8'h00, "R2 ram0 untouched by 0xA1");
    doRead(8'hB0, "R2 0xB0");
    doRead(8'hB2, "R2 0xB2");
    doRead(8'h7F, "R2 0x7F");
    doRead(8'h32, "R2 0x32");

    // time map
    doRead(8'h23, "R7 0x23 zero");
    doRead(8'h24, "R7 day");
    doRead(8'h25, "R7 month");
    doRead(8'h26, "R7 year");
    doRead(8'h2F, "R7 0x2F zero");

    // abort mid data phase
    xfer(8'h85, 8'hFF, 12, rd, oeErr);
    endXfer();
    doRead(8'h05, "R9 partial write dropped");
    xfer(8'h85, 8'hFF, 7, rd, oeErr);
    endXfer();
    doRead(8'h05, "R9 partial command dropped");

    // phases past 15
    xfer(8'h86, 8'h69, 21, rd, oeErr);
    check("R10 oe low past 15 on write", oeErr, 0);
    endXfer();
    mRam[6] = 8'h69;
    doRead(8'h06, "R10 extra edges ignored", 22);

    // random mix
    for (int k = 0; k < 80; k++) begin
      int kind;
      logic [7:0] c;
      kind = int'($urandom % 4);
      case (kind)
        0: doWrite(8'h80 + 8'($urandom % 32), 8'($urandom), "R3 random");
        1: doRead(8'($urandom % 32), "R5 random");
        2: begin
          c = 8'($urandom);
          if (isWr(c)) doWrite(c, 8'($urandom), "R2 random write");
          else         doRead(c, "R2 random read");
        end
        default: begin
          doWrite(8'hB1, 8'($urandom), "R4 random");
          doRead(8'h31, "R4 random");
        end
      endcase
    end

    // time counting
    tickRun(59);
    doRead(8'h20, "R11 sec 59");
    tickRun(1);
    doRead(8'h20, "R11 sec wrap");
    doRead(8'h21, "R11 min carry");
    tickRun(86399 - ticks);
    doRead(8'h20, "R11 23:59:59 sec");
    doRead(8'h21, "R11 23:59:59 min");
    doRead(8'h22, "R11 23:59:59 hour");
    tickRun(1);
    doRead(8'h22, "R11 hour wrap");
    doRead(8'h21, "R11 min after wrap");
    ticks = 0;
    doRead(8'h20, "R11 sec after wrap");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule